// File: doc/BRIEF.md
# Register-Driven SPI Command Tunnel

This block lets software run arbitrary SPI transactions through a handful of byte-wide registers. The host queues a command byte followed by up to fifteen payload bytes, stores the payload and response counts in one packed length register, and sets a start bit in the control register. The engine then holds chip select low and clocks out the queued bytes. Unless told not to, it clocks in the response bytes straight afterwards. The host drains those bytes one per read from a response register.

The control start bit stays set while the transaction runs, so software polls that bit to find out when the transaction has finished. Commands only run while a guard register holds its unlock value. The SPI side runs in mode 0. The SCLK half-period is a parameter counted in system clocks.

Register offsets: queue 0x90, response 0x91, length 0x92, control 0x93, guard 0xB3.

Top module: `spi_tunnel`

## Requirements
- R1: After reset, cs_n_o is high, sclk_o is low, the control register reads 0x00 and the guard register reads 0x00.
- R2: A transaction shifts out 1 + length[3:0] bytes, MSB first. Byte 0 is the first byte written to offset 0x90, and the later bytes follow in write order.
- R3: With control bit 2 clear, length[7:4] + 1 response bytes are clocked in right after the outgoing bytes. Each is captured MSB first on rising SCLK. Successive reads of offset 0x91 return them in arrival order.
- R4: With control bit 2 set, no response bytes are clocked, so exactly 8 × (1 + length[3:0]) SCLK rising edges occur.
- R5: Writing control bit 0 with the guard open starts a transaction. Bit 0 of the control register reads 1 from the next cycle until the last bit is done, and then reads 0. cs_n_o is low for exactly that span.
- R6: A start request is ignored unless offset 0xB3 holds 0x10 (for example, after 0x00 or 0x11 is written there). Bit 0 then reads back 0, and cs_n_o stays high.
- R7: Writing control bit 1, or the end of a transaction, returns the queue write position and the response read position to 0, so the next byte written becomes the command.
- R8: SCLK idles low whenever cs_n_o is high, and MOSI changes only while SCLK is low.
- R9: Writes to offset 0x90 beyond sixteen queued bytes are dropped, leaving the queued bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the response register) |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| sclk_o | output | 1 | SPI clock, idle low |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
The bench sweeps every payload count from 0 to 15 against read counts spread across 1 to 16. It alternates the no-read bit and checks bit totals arithmetically, so a length nibble decoded off by one shows up as a wrong number of SCLK edges. A seventeenth queue write is used to catch a queue that wraps and overwrites the command byte. A second transaction is queued without an explicit clear, which exposes a design that fails to rewind its pointers at completion. Start requests under closed guard values (0x00 and 0x11) must leave chip select untouched and read back as idle. A monitor flags any MOSI movement while SCLK is high.

// File: rtl/spi_tunnel_pkg.sv
package spi_tunnel_pkg;
  localparam logic [7:0] OFS_QUEUE = 8'h90;
  localparam logic [7:0] OFS_RESP  = 8'h91;
  localparam logic [7:0] OFS_LEN   = 8'h92;
  localparam logic [7:0] OFS_CTRL  = 8'h93;
  localparam logic [7:0] OFS_GUARD = 8'hB3;
  localparam logic [7:0] GUARD_KEY = 8'h10;
  localparam int CTRL_GO   = 0;
  localparam int CTRL_RWND = 1;
  localparam int CTRL_NORX = 2;
endpackage

// File: rtl/spi_tunnel_txq.sv
module spi_tunnel_txq #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [7:0]    data_i,
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    data_o,
  output logic [CW-1:0] count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i && (cnt_q < CW'(DEPTH))) begin
      mem_q[cnt_q[IW-1:0]] <= data_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_o  = mem_q[idx_i];
  assign count_o = cnt_q;
endmodule

// File: rtl/spi_tunnel_rxbuf.sv
module spi_tunnel_rxbuf #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [IW-1:0] widx_i,
  input  logic [7:0]    wdata_i,
  input  logic          pop_i,
  output logic [7:0]    data_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [IW-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (wr_i) mem_q[widx_i] <= wdata_i;
      if (clr_i)      rd_q <= '0;
      else if (pop_i) rd_q <= rd_q + 1'b1;
    end
  end

  assign data_o = mem_q[rd_q];
endmodule

// File: rtl/spi_tunnel_shift.sv
module spi_tunnel_shift #(
  parameter int HALF_DIV = 4,
  parameter int CNT_W    = 6,
  parameter int IDX_W    = 4,
  localparam int DIV_W = $clog2(HALF_DIV + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_tx_i,
  input  logic [CNT_W-1:0] n_rx_i,
  input  logic [7:0]       tx_byte_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] tx_idx_o,
  output logic             rx_we_o,
  output logic [IDX_W-1:0] rx_idx_o,
  output logic [7:0]       rx_byte_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             mosi_o
);
  logic             busy_q, sclk_q, done_q, rxwe_q;
  logic [CNT_W-1:0] byte_q, ntx_q, ntot_q, rxi_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       sh_q, rxb_q;
  logic             tick;

  assign tick = busy_q && (div_q == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0; rxwe_q <= 1'b0;
      byte_q <= '0; ntx_q <= '0; ntot_q <= '0; rxi_q <= '0;
      bit_q <= '0; div_q <= '0; sh_q <= '0; rxb_q <= '0;
    end else begin
      done_q <= 1'b0;
      rxwe_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        byte_q <= '0;
        bit_q  <= '0;
        div_q  <= '0;
        ntx_q  <= n_tx_i;
        ntot_q <= n_tx_i + n_rx_i;
      end else if (busy_q) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            sh_q   <= {sh_q[6:0], miso_i};  // sample on rising edge
          end else begin
            sclk_q <= 1'b0;                 // shift on falling edge
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              if (byte_q >= ntx_q) begin
                rxwe_q <= 1'b1;
                rxb_q  <= sh_q;
                rxi_q  <= byte_q - ntx_q;
              end
              byte_q <= byte_q + 1'b1;
              if ((byte_q + 1'b1) == ntot_q) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign tx_idx_o  = byte_q[IDX_W-1:0];
  assign rx_we_o   = rxwe_q;
  assign rx_idx_o  = rxi_q[IDX_W-1:0];
  assign rx_byte_o = rxb_q;
  assign sclk_o    = sclk_q;
  assign cs_n_o    = !busy_q;
  assign mosi_o    = busy_q && (byte_q < ntx_q) && tx_byte_i[3'd7 - bit_q];
endmodule

// File: rtl/spi_tunnel.sv
module spi_tunnel
  import spi_tunnel_pkg::*;
#(
  parameter int NIB_W    = 4,
  parameter int HALF_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       sclk_o,
  output logic       cs_n_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int DEPTH = 1 << NIB_W;
  localparam int CNT_W = NIB_W + 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [7:0]       guard_q, len_q, q_byte, resp_byte, rx_byte;
  logic [2:0]       ctl_q;
  logic             busy, done, rx_we, gate_open;
  logic             ctl_wr, start, rewind, push, pop;
  logic [NIB_W-1:0] tx_idx, rx_idx;
  logic [CW-1:0]    q_count;
  logic [CNT_W-1:0] n_tx, n_rx;

  assign gate_open = (guard_q == GUARD_KEY);
  assign ctl_wr    = reg_we_i && (reg_addr_i == OFS_CTRL) && !busy;
  assign start     = ctl_wr && reg_wdata_i[CTRL_GO] && gate_open;
  assign rewind    = (ctl_wr && reg_wdata_i[CTRL_RWND]) || done;
  assign push      = reg_we_i && (reg_addr_i == OFS_QUEUE) && !busy;
  assign pop       = reg_re_i && (reg_addr_i == OFS_RESP) && !busy;
  assign n_tx      = CNT_W'(len_q[NIB_W-1:0]) + 1'b1;
  assign n_rx      = reg_wdata_i[CTRL_NORX] ? '0 : CNT_W'(len_q[7:NIB_W]) + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_q <= '0;
      len_q   <= '0;
      ctl_q   <= '0;
    end else begin
      if (reg_we_i && (reg_addr_i == OFS_GUARD)) guard_q <= reg_wdata_i;
      if (reg_we_i && (reg_addr_i == OFS_LEN) && !busy) len_q <= reg_wdata_i;
      if (ctl_wr) ctl_q <= reg_wdata_i[4:2];
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      OFS_RESP:  reg_rdata_o = resp_byte;
      OFS_LEN:   reg_rdata_o = len_q;
      OFS_CTRL:  reg_rdata_o = {3'b000, ctl_q, 1'b0, busy};
      OFS_GUARD: reg_rdata_o = guard_q;
      default:   reg_rdata_o = 8'h00;
    endcase
  end

  spi_tunnel_txq #(.DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni, .clr_i(rewind), .push_i(push), .data_i(reg_wdata_i),
    .idx_i(tx_idx), .data_o(q_byte), .count_o(q_count)
  );

  spi_tunnel_rxbuf #(.DEPTH(DEPTH)) u_rxbuf (
    .clk_i, .rst_ni, .clr_i(rewind), .wr_i(rx_we), .widx_i(rx_idx),
    .wdata_i(rx_byte), .pop_i(pop), .data_o(resp_byte)
  );

  spi_tunnel_shift #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W), .IDX_W(NIB_W)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .n_tx_i(n_tx), .n_rx_i(n_rx),
    .tx_byte_i(q_byte), .miso_i, .busy_o(busy), .done_o(done),
    .tx_idx_o(tx_idx), .rx_we_o(rx_we), .rx_idx_o(rx_idx), .rx_byte_o(rx_byte),
    .sclk_o, .cs_n_o, .mosi_o
  );
endmodule

// File: rtl/spi_tunnel_chk.sv
module spi_tunnel_chk
  import spi_tunnel_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [7:0]    reg_addr_i,
  input logic [7:0]    reg_wdata_i,
  input logic          sclk_o,
  input logic          cs_n_o,
  input logic          mosi_o,
  input logic          gate_open,
  input logic          busy,
  input logic [CW-1:0] q_count
);
  p_sclk_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  p_mosi_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_CTRL && reg_wdata_i[CTRL_GO] && gate_open && !busy)
      |=> (!cs_n_o && busy));

  p_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_CTRL && !gate_open && !busy) |=> cs_n_o);

  p_rewind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_CTRL && reg_wdata_i[CTRL_RWND] && !busy)
      |=> (q_count == '0));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= CW'(DEPTH));
endmodule

bind spi_tunnel spi_tunnel_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
  .gate_open(gate_open), .busy(busy), .q_count(q_count)
);

// File: tb/tb_spi_tunnel.sv
module tb_spi_tunnel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       sclk, cs_n, mosi, miso;

  int n_chk = 0, n_bad = 0;
  int nbits = 0;
  int cur_n = 0;
  int viol = 0;
  bit cap [512];
  logic [7:0] exp_tx [16];
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;

  always #10 clk = ~clk;

  spi_tunnel #(.NIB_W(4), .HALF_DIV(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk), .cs_n_o(cs_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  function automatic logic [7:0] resp_byte(int i, int n);
    return 8'h5A ^ 8'((i * 29) + (n * 3));
  endfunction

  always_comb begin
    int b;
    b = nbits;
    if (b < 8 * (1 + cur_n)) miso = 1'b0;
    else miso = resp_byte((b / 8) - (1 + cur_n), cur_n)[7 - (b % 8)];
  end

  always @(posedge sclk) if (!cs_n && nbits < 512) begin
    cap[nbits] = mosi;
    nbits = nbits + 1;
  end

  always @(negedge clk) begin
    if (sclk && prev_sclk && mosi != prev_mosi) viol++;
    if (cs_n && sclk) viol++;
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #2 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic push(input logic [7:0] v, input int k);
    wr(8'h90, v);
    if (k < 16) exp_tx[k] = v;
  endtask

  task automatic load(input int n, input logic [7:0] base);
    for (int k = 0; k <= n; k++) push(8'(base + k * 37 + n), k);
  endtask

  // run one transaction and check it; expectations from the queued values
  task automatic fire(input int n, input int r, input bit nr, input string req);
    logic [7:0] v;
    int guard, tot, bad;
    cur_n = n;
    nbits = 0;
    wr(8'h92, 8'((r - 1) * 16 + n));
    wr(8'h93, nr ? 8'h05 : 8'h01);
    rd(8'h93, v);
    check(v[0] == 1'b1 && cs_n == 1'b0, "R5 busy while running", {v[0], cs_n}, 2);
    guard = 0;
    while (v[0] && guard < 5000) begin rd(8'h93, v); guard++; end
    check(v[0] == 1'b0 && cs_n == 1'b1, "R5 idle after end", {v[0], cs_n}, 1);
    tot = 8 * (1 + n + (nr ? 0 : r));
    check(nbits == tot, nr ? "R4 bit count" : "R3 bit count", nbits, tot);
    bad = 0;
    for (int j = 0; j <= n; j++) begin
      logic [7:0] got;
      for (int b = 0; b < 8; b++) got[7 - b] = cap[j * 8 + b];
      if (got !== exp_tx[j]) begin
        bad++;
        $display("FAIL %s byte %0d: actual %0h expected %0h", req, j, got, exp_tx[j]);
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
    if (!nr) for (int i = 0; i < r; i++) begin
      rd(8'h91, v);
      check(v == resp_byte(i, n), "R3 response pop", v, resp_byte(i, n));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0, "R1 idle lines", {cs_n, sclk}, 2);
    rd(8'h93, v); check(v == 8'h00, "R1 control reset", v, 0);
    rd(8'hB3, v); check(v == 8'h00, "R1 guard reset", v, 0);

    // R6: closed guard values
    load(0, 8'h9F);
    nbits = 0;
    wr(8'h93, 8'h01);
    rd(8'h93, v);
    check(v[0] == 1'b0 && cs_n == 1'b1 && nbits == 0, "R6 closed 00", v, 0);
    wr(8'hB3, 8'h11);
    wr(8'h93, 8'h01);
    rd(8'h93, v);
    check(v[0] == 1'b0 && cs_n == 1'b1 && nbits == 0, "R6 closed 11", v, 0);

    wr(8'hB3, 8'h10);
    rd(8'hB3, v); check(v == 8'h10, "R6 guard open", v, 8'h10);

    // R2/R3/R4 sweep over every payload count
    for (int n = 0; n < 16; n++) begin
      wr(8'h93, 8'h02);
      load(n, 8'h03 + 8'(n));
      fire(n, ((n * 7) % 16) + 1, n[0] == 1'b0 && n > 0, "R2 sweep");
    end

    // R7: completion rewinds the queue without an explicit clear
    load(2, 8'h61);
    fire(2, 3, 1'b0, "R7 auto rewind");

    // R7: explicit clear discards stale bytes
    for (int k = 0; k < 3; k++) wr(8'h90, 8'hEE);
    wr(8'h93, 8'h02);
    load(1, 8'h35);
    fire(1, 1, 1'b1, "R7 clear");

    // R9: a seventeenth byte is dropped
    for (int k = 0; k < 17; k++) push(8'hC0 + 8'(k), k);
    fire(15, 16, 1'b0, "R9 overflow");

    // R6: closing again blocks starts
    wr(8'hB3, 8'h00);
    load(0, 8'h77);
    nbits = 0;
    wr(8'h93, 8'h01);
    rd(8'h93, v);
    check(v[0] == 1'b0 && cs_n == 1'b1 && nbits == 0, "R6 reclosed", v, 0);

    check(viol == 0, "R8 mode 0 timing", viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule